// File: doc/BRIEF.md
# Pattern Dwell Trigger Recognizer

This block recognizes a trigger condition in a 16-channel timing capture path. A new sample of every channel arrives on each clock, and each sample comes with a flag per channel that marks a glitch seen between samples. Each channel is compared with a programmed level, or it is excluded from the comparison. The combined pattern counts as present only when every compared channel agrees with its level. The block counts how many samples in a row the pattern has been present and compares that count with a programmed dwell limit.

In the longer-than mode, the trigger fires once the pattern has been present for more than the dwell limit. A chained stage can add a further condition in this mode: after the dwell is met, and while the pattern is still present, a selected transition or a glitch must appear on an enabled channel. In the shorter-than mode, the trigger fires when a pattern ends before it reaches the limit. After any pattern that ends early, the recognizer ignores the pattern for a fixed recovery gap of two sample ticks.

Nothing fires until the block is armed, either from a local arm input or from an external trigger line. The output is a single-cycle pulse, and each pulse disarms the block.

Top module: `dwell_trigger`

## Requirements
- R1: A sample matches the pattern when, for every channel i, `pat_care[i]` is 0 or `smp_in[i]` equals `pat_val[i]`. A channel with `pat_care[i]=0` never affects the match.
- R2: The run length is the number of consecutive matching samples, counting the current one. A non-matching sample (or a sample ignored by R5) sets it to 0. It saturates at 2^DUR_W-1 and does not wrap.
- R3: With `mode_shorter=0` and `chain_en=0`, the block fires on the first sample, taken while armed, whose run length is greater than `dur_limit`. `trig` is high in the clock cycle after that sample.
- R4: With `mode_shorter=1`, the block fires on a non-matching sample that directly follows a run whose length L satisfies 1 <= L < `dur_limit`. A run with L >= `dur_limit` does not fire.
- R5: When a run ends with length L, where 1 <= L < `dur_limit` (in either mode), the next two samples are treated as non-matching. Counting restarts on the third sample.
- R6: With `mode_shorter=0` and `chain_en=1`, the block fires only on a sample whose run length is greater than `dur_limit` and in which some channel i with `edge_en[i]=1` shows an enabled event. The events are: a rise, from 0 in the previous sample to 1 now, allowed when `edge_kind[2i]=1`; a fall, allowed when `edge_kind[2i+1]=1`; or `glitch_in[i]=1`. After reset the previous sample counts as all zeros.
- R7: In the shorter-than mode, `chain_en` has no effect.
- R8: `arm` or `ext_arm` high at a clock edge arms the block from the next sample on. While the block is not armed, no condition fires.
- R9: `trig` is high for exactly one cycle per firing, and firing disarms the block. An arm request on the same sample as a firing is ignored.
- R10: After reset, `trig` is 0, the block is disarmed, the run length is 0 and no recovery gap is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one sample per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_in | input | N_CH | Sampled channel levels |
| glitch_in | input | N_CH | Per-channel glitch flags for this sample |
| pat_val | input | N_CH | Required level per channel |
| pat_care | input | N_CH | 1 = channel takes part in the pattern |
| dur_limit | input | DUR_W | Dwell limit in sample ticks |
| mode_shorter | input | 1 | 0 = longer-than, 1 = shorter-than |
| chain_en | input | 1 | Require an edge or glitch after the dwell (longer-than mode only) |
| edge_en | input | N_CH | Channels that take part in the chained stage |
| edge_kind | input | 2*N_CH | Per channel: bit 2i rise, bit 2i+1 fall |
| arm | input | 1 | Local arm request |
| ext_arm | input | 1 | Arm request from an external trigger line |
| trig | output | 1 | Single-cycle trigger pulse |

## Verification
The bench aims at several exact boundaries: a run of exactly `dur_limit` samples ending in shorter-than mode, the sample where the run first goes past the limit, and both recovery-gap ticks. A design that is off by one would fire a sample early or late, and a design with a one-tick gap would fire one sample too soon. With a narrow counter, a 300-sample run against the top limit exposes a counter that wraps, because the wrapped count looks like a short run and fires. In chained mode, edges of the disabled polarity, glitches on channels that are not enabled, and edges before the dwell is met must all stay silent. An arm request on the very sample that fires must not leave the block armed for a second pulse.

// File: rtl/dwell_trig_pkg.sv
package dwell_trig_pkg;

  localparam logic MODE_LONGER  = 1'b0;
  localparam logic MODE_SHORTER = 1'b1;

  // one channel's contribution to the pattern
  function automatic logic chan_ok(input logic s, input logic v, input logic c);
    return !c || (s == v);
  endfunction

  // one channel's contribution to the chained event stage
  // kind[0] enables rising, kind[1] enables falling
  function automatic logic chan_event(input logic en, input logic [1:0] kind,
                                      input logic prev, input logic cur,
                                      input logic glt);
    logic rose;
    logic fell;
    rose = !prev && cur;
    fell = prev && !cur;
    return en && (glt || (kind[0] && rose) || (kind[1] && fell));
  endfunction

endpackage

// File: rtl/dwell_pattern_match.sv
module dwell_pattern_match #(
  parameter int N_CH = 16
) (
  input  logic [N_CH-1:0] smp,
  input  logic [N_CH-1:0] pat_val,
  input  logic [N_CH-1:0] pat_care,
  output logic            hit
);
  logic [N_CH-1:0] ch_ok;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    assign ch_ok[i] = dwell_trig_pkg::chan_ok(smp[i], pat_val[i], pat_care[i]);
  end

  assign hit = &ch_ok;
endmodule

// File: rtl/dwell_edge_detect.sv
module dwell_edge_detect #(
  parameter int N_CH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CH-1:0]   smp,
  input  logic [N_CH-1:0]   glitch,
  input  logic [N_CH-1:0]   edge_en,
  input  logic [2*N_CH-1:0] edge_kind,
  output logic              edge_hit
);
  logic [N_CH-1:0] prev_q;
  logic [N_CH-1:0] ch_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= smp;
  end

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    assign ch_evt[i] = dwell_trig_pkg::chan_event(edge_en[i], edge_kind[2*i +: 2],
                                                  prev_q[i], smp[i], glitch[i]);
  end

  assign edge_hit = |ch_evt;
endmodule

// File: rtl/dwell_run_timer.sv
module dwell_run_timer #(
  parameter int DUR_W     = 16,
  parameter int GAP_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw_hit,
  input  logic [DUR_W-1:0] dur_limit,
  output logic             eff_hit,
  output logic [DUR_W-1:0] run_len,
  output logic [DUR_W-1:0] len_next,
  output logic             short_end,
  output logic             in_gap
);
  localparam int              GAP_W   = $clog2(GAP_TICKS + 1);
  localparam logic [DUR_W-1:0] RUN_MAX = {DUR_W{1'b1}};

  function automatic logic [DUR_W-1:0] sat_inc(input logic [DUR_W-1:0] v);
    return (v == RUN_MAX) ? v : v + DUR_W'(1);
  endfunction

  logic [DUR_W-1:0] run_q;
  logic [GAP_W-1:0] gap_q;
  logic [GAP_W-1:0] gap_d;

  assign in_gap    = (gap_q != '0);
  assign eff_hit   = raw_hit && !in_gap;
  assign len_next  = eff_hit ? sat_inc(run_q) : '0;
  assign short_end = !eff_hit && (run_q != '0) && (run_q < dur_limit);
  assign run_len   = run_q;

  always_comb begin
    if (short_end)   gap_d = GAP_W'(GAP_TICKS);
    else if (in_gap) gap_d = gap_q - GAP_W'(1);
    else             gap_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      gap_q <= '0;
    end else begin
      run_q <= len_next;
      gap_q <= gap_d;
    end
  end
endmodule

// File: rtl/dwell_trigger.sv
module dwell_trigger #(
  parameter int N_CH      = 16,
  parameter int DUR_W     = 16,
  parameter int GAP_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CH-1:0]   smp_in,
  input  logic [N_CH-1:0]   glitch_in,
  input  logic [N_CH-1:0]   pat_val,
  input  logic [N_CH-1:0]   pat_care,
  input  logic [DUR_W-1:0]  dur_limit,
  input  logic              mode_shorter,
  input  logic              chain_en,
  input  logic [N_CH-1:0]   edge_en,
  input  logic [2*N_CH-1:0] edge_kind,
  input  logic              arm,
  input  logic              ext_arm,
  output logic              trig
);
  import dwell_trig_pkg::*;

  logic             raw_hit;
  logic             eff_hit;
  logic [DUR_W-1:0] run_len;
  logic [DUR_W-1:0] len_next;
  logic             short_end;
  logic             in_gap;
  logic             edge_hit;
  logic             dwell_met;
  logic             event_c;
  logic             fire_c;
  logic             armed_q;
  logic             trig_q;

  dwell_pattern_match #(.N_CH(N_CH)) u_match (
    .smp      (smp_in),
    .pat_val  (pat_val),
    .pat_care (pat_care),
    .hit      (raw_hit)
  );

  dwell_run_timer #(.DUR_W(DUR_W), .GAP_TICKS(GAP_TICKS)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .raw_hit   (raw_hit),
    .dur_limit (dur_limit),
    .eff_hit   (eff_hit),
    .run_len   (run_len),
    .len_next  (len_next),
    .short_end (short_end),
    .in_gap    (in_gap)
  );

  dwell_edge_detect #(.N_CH(N_CH)) u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp       (smp_in),
    .glitch    (glitch_in),
    .edge_en   (edge_en),
    .edge_kind (edge_kind),
    .edge_hit  (edge_hit)
  );

  assign dwell_met = (len_next > dur_limit);

  always_comb begin
    if (mode_shorter == MODE_SHORTER) event_c = short_end;
    else if (chain_en)                event_c = dwell_met && edge_hit;
    else                              event_c = dwell_met;
  end

  assign fire_c = armed_q && event_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      trig_q  <= 1'b0;
    end else begin
      armed_q <= fire_c ? 1'b0 : (armed_q || arm || ext_arm);
      trig_q  <= fire_c;
    end
  end

  assign trig = trig_q;
endmodule

// File: rtl/dwell_trigger_chk.sv
module dwell_trigger_chk #(
  parameter int DUR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             eff_hit,
  input logic [DUR_W-1:0] run_len,
  input logic             short_end,
  input logic             in_gap,
  input logic             armed_q,
  input logic             trig
);
  localparam logic [DUR_W-1:0] RUN_MAX = {DUR_W{1'b1}};

  a_r2_clear_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    !eff_hit |=> run_len == '0);

  a_r2_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_hit && run_len != RUN_MAX) |=> run_len == ($past(run_len) + DUR_W'(1)));

  a_r2_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_hit && run_len == RUN_MAX) |=> run_len == RUN_MAX);

  a_r5_gap_first: assert property (@(posedge clk) disable iff (!rst_n)
    short_end |=> (in_gap && !eff_hit));

  a_r5_gap_second: assert property (@(posedge clk) disable iff (!rst_n)
    short_end |=> ##1 !eff_hit);

  a_r8_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> $past(armed_q));

  a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig);

  a_r9_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> !armed_q);
endmodule

bind dwell_trigger dwell_trigger_chk #(.DUR_W(DUR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .eff_hit   (eff_hit),
  .run_len   (run_len),
  .short_end (short_end),
  .in_gap    (in_gap),
  .armed_q   (armed_q),
  .trig      (trig)
);

// File: tb/dwell_trigger_tb.sv
module dwell_trigger_tb_top;
  localparam int N_CH  = 16;
  localparam int DUR_W = 8;
  localparam int RMAX  = (1 << DUR_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N_CH-1:0]   smp_in = '0;
  logic [N_CH-1:0]   glitch_in = '0;
  logic [N_CH-1:0]   pat_val = '0;
  logic [N_CH-1:0]   pat_care = '0;
  logic [DUR_W-1:0]  dur_limit = '0;
  logic              mode_shorter = 1'b0;
  logic              chain_en = 1'b0;
  logic [N_CH-1:0]   edge_en = '0;
  logic [2*N_CH-1:0] edge_kind = '0;
  logic              arm = 1'b0;
  logic              ext_arm = 1'b0;
  logic              trig;

  int total = 0;
  int fails = 0;
  bit started = 1'b0;

  always #5 clk = ~clk;

  dwell_trigger #(.N_CH(N_CH), .DUR_W(DUR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .smp_in(smp_in), .glitch_in(glitch_in),
    .pat_val(pat_val), .pat_care(pat_care), .dur_limit(dur_limit),
    .mode_shorter(mode_shorter), .chain_en(chain_en), .edge_en(edge_en),
    .edge_kind(edge_kind), .arm(arm), .ext_arm(ext_arm), .trig(trig)
  );

  // ---------------- reference model from the requirements ----------------
  int       m_run;
  int       m_gap;
  bit       m_armed;
  bit [N_CH-1:0] m_prev;
  bit       exp_trig;

  function automatic bit pattern_ok(input bit [N_CH-1:0] s);
    for (int i = 0; i < N_CH; i++)
      if (pat_care[i] && (s[i] != pat_val[i])) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit any_event(input bit [N_CH-1:0] s, input bit [N_CH-1:0] p);
    for (int i = 0; i < N_CH; i++) begin
      if (edge_en[i]) begin
        if (glitch_in[i]) return 1'b1;
        if (edge_kind[2*i] && !p[i] && s[i]) return 1'b1;
        if (edge_kind[2*i+1] && p[i] && !s[i]) return 1'b1;
      end
    end
    return 1'b0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_gap = 0; m_armed = 0; m_prev = '0; exp_trig = 0;
    end else begin
      bit hit, early, ev, f;
      int nl;
      hit   = pattern_ok(smp_in) && (m_gap == 0);
      nl    = hit ? ((m_run >= RMAX) ? RMAX : m_run + 1) : 0;
      early = !hit && (m_run >= 1) && (m_run < int'(dur_limit));
      if (mode_shorter)  ev = early;
      else if (chain_en) ev = (nl > int'(dur_limit)) && any_event(smp_in, m_prev);
      else               ev = (nl > int'(dur_limit));
      f = m_armed && ev;
      exp_trig = f;
      m_armed  = f ? 1'b0 : (m_armed || arm || ext_arm);
      m_gap    = early ? 2 : ((m_gap > 0) ? m_gap - 1 : 0);
      m_run    = nl;
      m_prev   = smp_in;
    end
  end

  always @(negedge clk) begin
    if (rst_n && started) begin
      total++;
      if (trig !== exp_trig) begin
        fails++;
        $display("FAIL R3 R4 R6 model compare t=%0t: trig=%0b expected %0b", $time, trig, exp_trig);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit exp, input string tag);
    total++;
    if (trig !== exp) begin
      fails++;
      $display("FAIL %s t=%0t: trig=%0b expected %0b", tag, $time, trig, exp);
    end
  endtask

  task automatic step(input bit [N_CH-1:0] s, input bit [N_CH-1:0] g,
                      input bit a, input bit xa);
    @(negedge clk);
    smp_in = s; glitch_in = g; arm = a; ext_arm = xa;
    @(posedge clk);
    #1;
  endtask

  function automatic bit [N_CH-1:0] mk();
    bit [N_CH-1:0] r;
    r = N_CH'($urandom);
    return (pat_val & pat_care) | (r & ~pat_care);
  endfunction

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog: run still active, expected completion");
    finish_run();
  end

  initial begin
    bit [N_CH-1:0] mis;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1;
    check(1'b0, "R10 reset trig");
    rst_n = 1'b1;
    started = 1'b1;

    // R8: unarmed, condition true at every sample
    pat_care = 16'h0001; pat_val = 16'h0001; dur_limit = 0;
    for (int k = 0; k < 4; k++) begin step(16'h0001, 0, 0, 0); check(1'b0, "R8 unarmed"); end

    // R1 R3: longer-than, dur 3
    pat_care = 16'h00FF; pat_val = 16'h00A5; dur_limit = 3;
    mis = 16'h00A4;
    step(mis, 0, 1, 0); check(1'b0, "R3 arm");
    for (int k = 0; k < 3; k++) begin step(mk(), 0, 0, 0); check(1'b0, "R3 not yet"); end
    step(mk(), 0, 0, 0); check(1'b1, "R3 fire");
    step(mk(), 0, 0, 0); check(1'b0, "R9 pulse");
    step(mk(), 0, 0, 0); check(1'b0, "R9 disarmed");

    // R1 R2: mismatch on cared bit restarts count
    step(mis, 0, 1, 0); check(1'b0, "R2 rearm");
    for (int k = 0; k < 3; k++) begin step(mk(), 0, 0, 0); check(1'b0, "R1 run"); end
    step(mk() ^ 16'h0008, 0, 0, 0); check(1'b0, "R1 cared mismatch");
    for (int k = 0; k < 3; k++) begin step(mk(), 0, 0, 0); check(1'b0, "R2 restart"); end
    step(mk(), 0, 0, 0); check(1'b1, "R2 restart fire");

    // R5: two-tick gap after an early end
    step(mis, 0, 1, 0); check(1'b0, "R5 rearm");
    step(mk(), 0, 0, 0); step(mk(), 0, 0, 0);
    step(mis, 0, 0, 0); check(1'b0, "R5 early end");
    for (int k = 0; k < 5; k++) begin step(mk(), 0, 0, 0); check(1'b0, "R5 gap"); end
    step(mk(), 0, 0, 0); check(1'b1, "R5 fire after gap");

    // R4: shorter-than, dur 4
    mode_shorter = 1'b1; dur_limit = 4;
    step(mis, 0, 1, 0); check(1'b0, "R4 arm");
    for (int k = 0; k < 4; k++) step(mk(), 0, 0, 0);
    step(mis, 0, 0, 0); check(1'b0, "R4 length equal to limit");
    for (int k = 0; k < 3; k++) step(mk(), 0, 0, 0);
    step(mis, 0, 0, 0); check(1'b1, "R4 short fire");

    // R7: chain has no effect in shorter mode
    chain_en = 1'b1;
    step(mis, 0, 1, 0); step(mis, 0, 0, 0);
    step(mk(), 0, 0, 0); step(mk(), 0, 0, 0);
    step(mis, 0, 0, 0); check(1'b1, "R7 chain ignored");

    // R6: chained edge stage, channel 5 rising only
    mode_shorter = 1'b0; dur_limit = 2;
    pat_care = 16'h0001; pat_val = 16'h0001;
    edge_en = 16'h0020; edge_kind = 32'h0000_0400;
    step(16'h0000, 0, 1, 0); step(16'h0000, 0, 0, 0);
    step(16'h0001, 0, 0, 0); check(1'b0, "R6 len1");
    step(16'h0021, 0, 0, 0); check(1'b0, "R6 rise before dwell");
    step(16'h0001, 0, 0, 0); check(1'b0, "R6 fall not enabled");
    step(16'h0001, 16'h0040, 0, 0); check(1'b0, "R6 glitch on disabled channel");
    step(16'h0021, 0, 0, 0); check(1'b1, "R6 rise fires");
    step(16'h0021, 0, 1, 0); check(1'b0, "R6 rearm");
    step(16'h0021, 16'h0020, 0, 0); check(1'b1, "R6 glitch fires");

    // R9 R8: arm on the firing sample is ignored; external arm works
    chain_en = 1'b0; dur_limit = 0; edge_en = '0; edge_kind = '0;
    step(16'h0000, 0, 1, 0); check(1'b0, "R9 arm");
    step(16'h0001, 0, 1, 0); check(1'b1, "R9 fire with arm");
    step(16'h0001, 0, 0, 0); check(1'b0, "R9 same-cycle arm ignored");
    step(16'h0001, 0, 0, 1); check(1'b0, "R8 ext arm");
    step(16'h0001, 0, 0, 0); check(1'b1, "R8 ext arm fire");

    // R2: saturation, no wrap
    mode_shorter = 1'b1; dur_limit = DUR_W'(RMAX);
    step(16'h0000, 0, 1, 0);
    for (int k = 0; k < 300; k++) step(16'h0001, 0, 0, 0);
    step(16'h0000, 0, 0, 0); check(1'b0, "R2 saturated run not short");
    mode_shorter = 1'b0; dur_limit = DUR_W'(RMAX - 1);
    for (int k = 0; k < RMAX - 1; k++) step(16'h0001, 0, 0, 0);
    check(1'b0, "R3 at limit");
    step(16'h0001, 0, 0, 0); check(1'b1, "R3 past limit at top of range");

    // random phase, checked by the model compare
    for (int k = 0; k < 4000; k++) begin
      if (k % 64 == 0) begin
        mode_shorter = 1'($urandom);
        chain_en     = 1'($urandom);
        dur_limit    = DUR_W'($urandom % 8);
        pat_care     = N_CH'($urandom & $urandom & $urandom);
        pat_val      = N_CH'($urandom);
        edge_en      = N_CH'($urandom & $urandom);
        edge_kind    = $urandom;
      end
      step(($urandom % 4 != 0) ? mk() : N_CH'($urandom),
           ($urandom % 8 == 0) ? N_CH'(1 << ($urandom % 16)) : '0,
           ($urandom % 8 == 0), ($urandom % 16 == 0));
    end

    finish_run();
  end
endmodule